// File: doc/BRIEF.md
# Buffered-Reload Countdown Tick Timer

A memory-mapped down-counting timer that produces a periodic interrupt, such as an operating-system tick. Software loads a reload value into a count buffer register. That value moves into the active reload latch only when software writes the control register with the manual-update bit set. A later control write with the start bit set, and the manual-update bit clear, loads the counter from the latch and starts counting. The counter steps down by one on each cycle where the tick-enable strobe is high. The strobe stands in for the selected timer input clock. When the count runs out, the interrupt pulses for one cycle. If the auto-reload bit is set, the counter restarts from the latched value. Otherwise it stops at zero.

The register file has 17 words of 32 bits. The word index is taken from byte-address bits [6:2]. Word 0 and word 1 are configuration words, word 2 is control, word 15 is the count buffer and word 16 is the read-only count observation. Words 3 to 14 are plain read/write storage. The bus is a single-cycle valid/write/address/data port. Read data is registered.

The sequencer has four states:
- STOPPED: idle.
- COUNTING: the counter is active.
- FIRE_RELOAD: an expiry has occurred and the counter reloaded.
- FIRE_HALT: an expiry has occurred and the counter halted.

It has these transitions:
- start: any state to COUNTING, on a start command.
- stop: any state to STOPPED, on a stop command.
- step: COUNTING or FIRE_RELOAD to COUNTING, on a tick that does not expire the count, or on a cycle with no tick.
- rearm: COUNTING or FIRE_RELOAD to FIRE_RELOAD, on an expiring tick with auto-reload set.
- expire: COUNTING or FIRE_RELOAD to FIRE_HALT, on an expiring tick with auto-reload clear.
- settle: FIRE_HALT to STOPPED.

The interrupt is high in exactly the two FIRE states.

Top module: `tick_timer`

## Requirements
- R1: After reset, every register reads 0, the count observation (word 16) reads 0, the interrupt is low and the timer is stopped.
- R2: The word index is byte-address bits [6:2]; bit 7 and the two low bits are ignored. Words 0 to 15 read back the last value written. Read data appears on `bus_rdata` on the cycle after the read request.
- R3: Writes to word indices 17 to 31 are ignored, and reads of those indices return 0.
- R4: A control write (word 2) with bit 21 set copies the count buffer (word 15) into the reload latch. It leaves the counter and the running state unchanged.
- R5: A control write with bit 21 clear and bit 20 set loads the counter from the reload latch and starts counting, restarting the count if the timer is already running. A write to the count buffer alone does not change the counter.
- R6: While the timer is counting, each cycle with `tick_en` high lowers the count by one. Cycles with `tick_en` low leave the count unchanged.
- R7: A tick that finds the count at 1 or 0 is an expiry. On the cycle after an expiring tick, `irq` is high, and it is high for one cycle per expiry.
- R8: On expiry with control bit 22 set, the counter reloads from the reload latch and keeps counting. With bit 22 clear, the count stays at 0 and the timer stops, ignoring further ticks.
- R9: A control write with bits 21 and 20 both clear stops counting. The count is frozen and the reload latch is unchanged.
- R10: Word 16 reads the current count, and writes to word 16 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | Bus request this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W (8) | Byte address |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_rdata | output | DATA_W (32) | Registered read data |
| tick_en | input | 1 | Count strobe from the selected timer clock |
| irq | output | 1 | One-cycle expiry pulse |

## Verification
The bench goes after these corner cases:
- A reload of 0 or 1. An off-by-one in the expiry test would either wrap the counter to all ones or miss the interrupt.
- Auto-reload with a reload of 1. This must give one interrupt pulse per tick; a design that dropped the pulse in the back-to-back FIRE_RELOAD case would undercount.
- Count-buffer writes, observation-word writes and a manual update issued while the timer is running. A design that leaked the buffer straight into the counter, or restarted on the manual update, would show a jump in the observed count.
- Ticks after a non-reloading expiry, and a stop followed by a restart without a new manual update. A timer that kept counting or lost its latch would read back the wrong value.

// File: rtl/tick_timer_pkg.sv
package tick_timer_pkg;

    // Sequencer states
    typedef enum logic [1:0] {
        ST_STOPPED     = 2'd0,
        ST_COUNTING    = 2'd1,
        ST_FIRE_RELOAD = 2'd2,
        ST_FIRE_HALT   = 2'd3
    } tmr_state_e;

    // Word indices whose position other logic decodes
    localparam int unsigned IDX_CTRL   = 2;
    localparam int unsigned IDX_BUFFER = 15;
    localparam int unsigned IDX_OBSERVE = 16;
    localparam int unsigned WORD_COUNT = 17;

    // Control-word bit positions
    localparam int unsigned BIT_GO     = 20;
    localparam int unsigned BIT_LATCH  = 21;
    localparam int unsigned BIT_REPEAT = 22;

endpackage

// File: rtl/tick_timer_decode.sv
module tick_timer_decode #(
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned DATA_W = 32,
    parameter int unsigned IDX_W  = 5
) (
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [IDX_W-1:0]  word_idx,
    output logic              wr_en,
    output logic              rd_en,
    output logic              cmd_valid,
    output logic              cmd_go,
    output logic              latch_req
);
    import tick_timer_pkg::*;

    logic ctrl_hit;

    always_comb begin
        word_idx  = bus_addr[IDX_W+1:2];
        wr_en     = bus_valid && bus_write;
        rd_en     = bus_valid && !bus_write;
        ctrl_hit  = wr_en && (word_idx == IDX_W'(IDX_CTRL));
        latch_req = ctrl_hit && bus_wdata[BIT_LATCH];
        // start/stop command only when the manual-update bit is clear
        cmd_valid = ctrl_hit && !bus_wdata[BIT_LATCH];
        cmd_go    = bus_wdata[BIT_GO];
    end

endmodule

// File: rtl/tick_timer_regfile.sv
module tick_timer_regfile #(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned IDX_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic              latch_req,
    input  logic [IDX_W-1:0]  word_idx,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W-1:0] live_count,
    output logic [DATA_W-1:0] rdata,
    output logic [DATA_W-1:0] ctrl_word,
    output logic [DATA_W-1:0] reload_val
);
    import tick_timer_pkg::*;

    localparam int unsigned NUM_STORED = IDX_OBSERVE;
    localparam int unsigned SEL_W      = $clog2(NUM_STORED);

    logic [DATA_W-1:0] word_q [NUM_STORED];
    logic [DATA_W-1:0] read_mux;

    // One storage word per writable index
    for (genvar w = 0; w < NUM_STORED; w++) begin : g_word
        logic [DATA_W-1:0] q;
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                q <= '0;
            end else if (wr_en && (word_idx == IDX_W'(w))) begin
                q <= wdata;
            end
        end
        assign word_q[w] = q;
    end

    assign ctrl_word = word_q[IDX_CTRL];

    // Manual update: buffer word into the reload latch
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reload_val <= '0;
        end else if (latch_req) begin
            reload_val <= word_q[IDX_BUFFER];
        end
    end

    always_comb begin
        if (word_idx < IDX_W'(NUM_STORED)) begin
            read_mux = word_q[word_idx[SEL_W-1:0]];
        end else if (word_idx == IDX_W'(IDX_OBSERVE)) begin
            read_mux = live_count;
        end else begin
            read_mux = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata <= '0;
        end else if (rd_en) begin
            rdata <= read_mux;
        end
    end

    // R4: the latch takes the buffer value seen at the control write
    p_latch_copy_r4: assert property (@(posedge clk) disable iff (!rst_n)
        latch_req |=> (reload_val == $past(word_q[IDX_BUFFER])));

    // R3: out-of-range indices read as zero
    p_unmapped_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && (word_idx > IDX_W'(IDX_OBSERVE))) |=> (rdata == '0));

    // R10: observation word reads the live count
    p_observe_live_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && (word_idx == IDX_W'(IDX_OBSERVE))) |=> (rdata == $past(live_count)));

endmodule

// File: rtl/tick_timer_core.sv
module tick_timer_core #(
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic              cmd_valid,
    input  logic              cmd_go,
    input  logic              repeat_en,
    input  logic [DATA_W-1:0] reload_val,
    output logic [DATA_W-1:0] count,
    output logic              irq
);
    import tick_timer_pkg::*;

    localparam logic [DATA_W-1:0] ONE = DATA_W'(1);

    tmr_state_e        state_q, state_d;
    logic [DATA_W-1:0] count_d;
    logic              active;
    logic              expiring;

    always_comb begin
        active   = (state_q == ST_COUNTING) || (state_q == ST_FIRE_RELOAD);
        expiring = active && tick_en && (count <= ONE);
    end

    // Next-state and next-count
    always_comb begin
        state_d = state_q;
        count_d = count;
        if (cmd_valid) begin
            if (cmd_go) begin
                state_d = ST_COUNTING;
                count_d = reload_val;
            end else begin
                state_d = ST_STOPPED;
            end
        end else begin
            unique case (state_q)
                ST_STOPPED: begin
                    state_d = ST_STOPPED;
                end
                ST_FIRE_HALT: begin
                    state_d = ST_STOPPED;
                end
                ST_COUNTING, ST_FIRE_RELOAD: begin
                    if (expiring) begin
                        if (repeat_en) begin
                            state_d = ST_FIRE_RELOAD;
                            count_d = reload_val;
                        end else begin
                            state_d = ST_FIRE_HALT;
                            count_d = '0;
                        end
                    end else begin
                        state_d = ST_COUNTING;
                        if (tick_en) begin
                            count_d = count - ONE;
                        end
                    end
                end
                default: begin
                    state_d = ST_STOPPED;
                end
            endcase
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_STOPPED;
            count   <= '0;
        end else begin
            state_q <= state_d;
            count   <= count_d;
        end
    end

    // Outputs
    always_comb begin
        unique case (state_q)
            ST_FIRE_RELOAD, ST_FIRE_HALT: irq = 1'b1;
            default:                      irq = 1'b0;
        endcase
    end

    // R6: a non-expiring tick lowers the count by one
    p_tick_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (active && tick_en && (count > ONE) && !cmd_valid)
        |=> (count == $past(count) - ONE));

    // R6: no tick, no change while counting
    p_no_tick_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !tick_en && !cmd_valid) |=> $stable(count));

    // R8: repeat expiry reloads and raises the interrupt
    p_rearm_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (expiring && repeat_en && !cmd_valid)
        |=> (irq && (count == $past(reload_val))));

    // R8: non-repeat expiry parks at zero, then stops
    p_halt_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FIRE_HALT) |-> (count == '0));

    // R9: a stop command freezes the count
    p_stop_freeze_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !cmd_go) |=> ((state_q == ST_STOPPED) && $stable(count)));

    // R7: the interrupt rises only after an expiring tick
    p_irq_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!expiring || cmd_valid) |=> !irq);

endmodule

// File: rtl/tick_timer.sv
module tick_timer #(
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              tick_en,
    output logic              irq
);
    import tick_timer_pkg::*;

    localparam int unsigned IDX_W = 5;

    logic [IDX_W-1:0]  word_idx;
    logic              wr_en;
    logic              rd_en;
    logic              cmd_valid;
    logic              cmd_go;
    logic              latch_req;
    logic [DATA_W-1:0] ctrl_word;
    logic [DATA_W-1:0] reload_val;
    logic [DATA_W-1:0] count;

    tick_timer_decode #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .IDX_W  (IDX_W)
    ) u_decode (
        .bus_valid (bus_valid),
        .bus_write (bus_write),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .word_idx  (word_idx),
        .wr_en     (wr_en),
        .rd_en     (rd_en),
        .cmd_valid (cmd_valid),
        .cmd_go    (cmd_go),
        .latch_req (latch_req)
    );

    tick_timer_regfile #(
        .DATA_W (DATA_W),
        .IDX_W  (IDX_W)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .rd_en      (rd_en),
        .latch_req  (latch_req),
        .word_idx   (word_idx),
        .wdata      (bus_wdata),
        .live_count (count),
        .rdata      (bus_rdata),
        .ctrl_word  (ctrl_word),
        .reload_val (reload_val)
    );

    tick_timer_core #(
        .DATA_W (DATA_W)
    ) u_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_en    (tick_en),
        .cmd_valid  (cmd_valid),
        .cmd_go     (cmd_go),
        .repeat_en  (ctrl_word[BIT_REPEAT]),
        .reload_val (reload_val),
        .count      (count),
        .irq        (irq)
    );

    // R1: nothing fires right after reset
    p_reset_quiet_r1: assert property (@(posedge clk)
        $rose(rst_n) |-> (!irq && (bus_rdata == '0)));

endmodule

// File: tb/tick_timer_test.sv
`timescale 1ns/1ps
module tick_timer_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_valid = 1'b0;
    logic        bus_write = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        tick_en = 1'b0;
    logic        irq;

    int checks = 0;
    int fails  = 0;
    int irq_seen = 0;
    logic [31:0] rv;

    localparam logic [31:0] GO  = 32'h0010_0000;
    localparam logic [31:0] UPD = 32'h0020_0000;
    localparam logic [31:0] REP = 32'h0040_0000;

    typedef struct packed {
        logic [31:0] reload;
        logic        rep;
        logic [7:0]  ticks;
        logic [31:0] exp_count;
        logic [7:0]  exp_irqs;
    } vec_t;

    localparam int NVEC = 9;
    localparam vec_t VECS [NVEC] = '{
        '{32'd10,  1'b0, 8'd3,  32'd7,   8'd0},
        '{32'd4,   1'b0, 8'd4,  32'd0,   8'd1},
        '{32'd4,   1'b0, 8'd9,  32'd0,   8'd1},
        '{32'd1,   1'b0, 8'd1,  32'd0,   8'd1},
        '{32'd0,   1'b0, 8'd2,  32'd0,   8'd1},
        '{32'd3,   1'b1, 8'd7,  32'd2,   8'd2},
        '{32'd1,   1'b1, 8'd4,  32'd1,   8'd4},
        '{32'd0,   1'b1, 8'd3,  32'd0,   8'd3},
        '{32'd300, 1'b0, 8'd40, 32'd260, 8'd0}
    };

    tick_timer uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_valid (bus_valid),
        .bus_write (bus_write),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .tick_en   (tick_en),
        .irq       (irq)
    );

    always #10 clk = ~clk;

    always @(negedge clk) if (irq) irq_seen++;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    task automatic wr_addr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0;
    endtask

    task automatic wr(input int idx, input logic [31:0] d);
        wr_addr(8'(idx << 2), d);
    endtask

    task automatic rd(input int idx, output logic [31:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b0; bus_addr = 8'(idx << 2);
        @(negedge clk);
        bus_valid = 1'b0;
        d = bus_rdata;
    endtask

    task automatic tick(input int n);
        @(negedge clk);
        tick_en = 1'b1;
        repeat (n) @(negedge clk);
        tick_en = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run did not complete, got 1 expected 0");
        finish_run();
    end

    initial begin
        int base;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        check("R1 irq after reset", 32'(irq), 32'd0);
        rd(0, rv);  check("R1 word0", rv, 32'd0);
        rd(2, rv);  check("R1 control", rv, 32'd0);
        rd(15, rv); check("R1 buffer", rv, 32'd0);
        rd(16, rv); check("R1 observe", rv, 32'd0);

        // R2: readback and address masking
        wr(0, 32'hA5A5_0001);
        wr(1, 32'h1234_5678);
        wr(14, 32'hDEAD_BEEF);
        wr_addr(8'h8C, 32'h0000_0055);
        rd(0, rv);  check("R2 word0", rv, 32'hA5A5_0001);
        rd(1, rv);  check("R2 word1", rv, 32'h1234_5678);
        rd(14, rv); check("R2 word14", rv, 32'hDEAD_BEEF);
        rd(3, rv);  check("R2 bit7 ignored", rv, 32'h0000_0055);

        // R3: unmapped indices
        wr(17, 32'hFFFF_FFFF);
        wr(31, 32'hFFFF_FFFF);
        rd(17, rv); check("R3 index17", rv, 32'd0);
        rd(31, rv); check("R3 index31", rv, 32'd0);
        rd(0, rv);  check("R3 word0 untouched", rv, 32'hA5A5_0001);

        // R5 / R6 / R10 / R4 / R9 while running
        wr(15, 32'd20);
        wr(2, UPD);
        rd(16, rv); check("R4 latch alone does not start", rv, 32'd0);
        wr(2, GO);
        rd(16, rv); check("R5 start loads reload", rv, 32'd20);
        tick(5);
        rd(16, rv); check("R6 five ticks", rv, 32'd15);
        repeat (4) @(negedge clk);
        rd(16, rv); check("R6 idle holds", rv, 32'd15);
        wr(15, 32'd99);
        rd(16, rv); check("R5 buffer write no effect", rv, 32'd15);
        wr(16, 32'h0000_0777);
        rd(16, rv); check("R10 observe write ignored", rv, 32'd15);
        wr(2, UPD | GO);
        rd(16, rv); check("R4 update keeps count", rv, 32'd15);
        tick(1);
        rd(16, rv); check("R4 still counting", rv, 32'd14);
        wr(2, 32'd0);
        tick(3);
        rd(16, rv); check("R9 stop freezes", rv, 32'd14);
        wr(2, GO);
        rd(16, rv); check("R9 latch kept, R5 restart", rv, 32'd99);
        tick(2);
        wr(2, GO);
        rd(16, rv); check("R5 restart while running", rv, 32'd99);
        wr(2, 32'd0);
        rd(2, rv);  check("R2 control readback", rv, 32'd0);
        rd(15, rv); check("R2 buffer readback", rv, 32'd99);

        // R7: one-cycle pulse
        wr(15, 32'd2);
        wr(2, UPD);
        wr(2, GO);
        tick(1);
        check("R7 no irq before expiry", 32'(irq), 32'd0);
        tick(1);
        check("R7 irq after expiring tick", 32'(irq), 32'd1);
        @(negedge clk);
        check("R7 irq single cycle", 32'(irq), 32'd0);
        tick(3);
        rd(16, rv); check("R8 halted at zero", rv, 32'd0);
        check("R8 no irq once stopped", 32'(irq), 32'd0);

        // Vector table: R6 / R7 / R8
        for (int i = 0; i < NVEC; i++) begin
            wr(2, 32'd0);
            wr(15, VECS[i].reload);
            wr(2, UPD | (VECS[i].rep ? REP : 32'd0));
            wr(2, GO | (VECS[i].rep ? REP : 32'd0));
            base = irq_seen;
            tick(int'(VECS[i].ticks));
            rd(16, rv);
            check($sformatf("R8 vector %0d count", i), rv, VECS[i].exp_count);
            check($sformatf("R7 vector %0d irq pulses", i), 32'(irq_seen - base),
                  32'(VECS[i].exp_irqs));
        end
        wr(2, 32'd0);

        finish_run();
    end

endmodule